// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recently used page mappings and turns a 32-bit virtual address into a 30-bit physical address. Pages are 4 KiB. The page number is looked up against every resident entry at once, so a mapping may sit in any slot. A requester presents an address and a read/write flag. One cycle later it gets a hit or a miss, the translated address and a flag that marks a write to a read-only page.

On a miss the requester waits while an external page walker reads the page table. The walker then installs the mapping through the fill port, and the requester repeats the same access. Each entry carries a referenced bit and a modified bit, which hits keep up to date. When a fill replaces an entry whose status is worth keeping, that entry's page number and status come out on the eviction port so the walker can update the page table. A flush input drops every mapping at once.

Top module: `xlat_tlb`

## Requirements
- R1: After reset no entry is valid: `rsp_valid` and `evict_valid` are 0, and every lookup misses until a fill is made.
- R2: `rsp_valid` is 1 in exactly the cycles that follow a cycle with `req_valid` = 1, so the response is registered one cycle after the request.
- R3: A lookup hits when a valid entry's stored page number equals address bits 31..12. On a hit `rsp_paddr` is the entry's 18-bit physical page number in bits 29..12 above address bits 11..0. On a miss `rsp_hit` and `rsp_paddr` are 0.
- R4: A hit sets the matching entry's referenced bit. A write hit to a writable entry also sets its modified bit. A read hit never sets the modified bit.
- R5: `rsp_wr_fault` is 1 only for a write that hits a read-only entry (filled with `fill_writable` = 0). Such a write sets the referenced bit but not the modified bit.
- R6: A fill chooses its slot in this order: the slot already holding the same page number, then the lowest-numbered invalid slot, then the lowest-numbered slot whose referenced bit is 0.
- R7: When every slot is valid and referenced, a fill clears all referenced bits and takes the slot named by a rotating pointer. The pointer starts at 0 after reset and advances by one, wrapping after the last slot, each time this case occurs.
- R8: When a fill replaces a valid slot whose modified or referenced bit is 1, `evict_valid` is 1 for the next cycle only. `evict_vpn`, `evict_dirty` and `evict_ref` then show that slot's page number and its status as it stood before the fill.
- R9: `flush` invalidates every entry at one clock edge. A fill in the same cycle is dropped and produces no eviction.
- R10: A fill installs its entry with both status bits 0. Lookups in a cycle see the entries as they stood before that cycle's edge. If a fill replaces the slot that a same-cycle request hits, the fill's values win.
- R11: No page number is ever resident in more than one valid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store, 0 for a load |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_ppn | input | 18 | Physical page number of the mapping |
| fill_writable | input | 1 | Mapping allows writes |
| flush | input | 1 | Invalidate all mappings |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_hit | output | 1 | Mapping was resident |
| rsp_paddr | output | 30 | Translated address (0 on miss) |
| rsp_wr_fault | output | 1 | Write hit a read-only mapping |
| evict_valid | output | 1 | Replaced entry needs write-back |
| evict_vpn | output | 20 | Page number of the replaced entry |
| evict_dirty | output | 1 | Replaced entry was modified |
| evict_ref | output | 1 | Replaced entry was referenced |

## Verification
Every result of this block is due at the clock edge that ends the cycle of its stimulus. The response fields follow a request by one edge, an eviction report follows its fill by one edge, and referenced and modified bits that a hit changes can only be seen through a later eviction. The bench drives each cycle's inputs on the falling edge. It updates its behavioural model in the same step and compares all outputs shortly after the next rising edge, so each expected value is matched with the one register stage that produces it. Status-bit effects are checked by forcing replacements in directed sequences and in a long random run over a small page pool.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned XL_VADDR_W   = 32;
  localparam int unsigned XL_PADDR_W   = 30;
  localparam int unsigned XL_OFFSET_W  = 12;
  localparam int unsigned XL_ENTRIES   = 16;

  // How a fill picked its slot, in priority order.
  typedef enum logic [1:0] {
    VIC_SAME  = 2'd0,   // slot already holds this page
    VIC_FREE  = 2'd1,   // an invalid slot
    VIC_COLD  = 2'd2,   // a valid slot not referenced lately
    VIC_SWEEP = 2'd3    // all referenced: clear and rotate
  } vic_kind_e;

endpackage

// File: rtl/xlat_first_set.sv
module xlat_first_set #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Lowest set bit wins: scan from the top so the lowest assignment lands last.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int unsigned N     = 16,
  parameter int unsigned TAG_W = 20
) (
  input  logic [N*TAG_W-1:0] tags_flat,
  input  logic [N-1:0]       valid,
  input  logic [TAG_W-1:0]   key,
  output logic [N-1:0]       match
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags_flat[g*TAG_W +: TAG_W] == key);
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  same_vec,
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  refd,
  input  logic [IW-1:0] sweep_ptr,
  output logic [IW-1:0] vic_idx,
  output vic_kind_e     vic_kind
);

  logic          same_found, free_found, cold_found;
  logic [IW-1:0] same_idx, free_idx, cold_idx;
  logic [N-1:0]  cold_vec;

  assign cold_vec = valid & ~refd;

  xlat_first_set #(.N(N), .IW(IW)) i_same (
    .vec(same_vec), .found(same_found), .idx(same_idx)
  );
  xlat_first_set #(.N(N), .IW(IW)) i_free (
    .vec(~valid), .found(free_found), .idx(free_idx)
  );
  xlat_first_set #(.N(N), .IW(IW)) i_cold (
    .vec(cold_vec), .found(cold_found), .idx(cold_idx)
  );

  always_comb begin
    if (same_found) begin
      vic_idx  = same_idx;
      vic_kind = VIC_SAME;
    end else if (free_found) begin
      vic_idx  = free_idx;
      vic_kind = VIC_FREE;
    end else if (cold_found) begin
      vic_idx  = cold_idx;
      vic_kind = VIC_COLD;
    end else begin
      vic_idx  = sweep_ptr;
      vic_kind = VIC_SWEEP;
    end
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int unsigned VADDR_W  = XL_VADDR_W,
  parameter int unsigned PADDR_W  = XL_PADDR_W,
  parameter int unsigned OFFSET_W = XL_OFFSET_W,
  parameter int unsigned ENTRIES  = XL_ENTRIES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [VADDR_W-1:0]            req_vaddr,
  input  logic                          req_write,
  input  logic                          fill_valid,
  input  logic [VADDR_W-OFFSET_W-1:0]   fill_vpn,
  input  logic [PADDR_W-OFFSET_W-1:0]   fill_ppn,
  input  logic                          fill_writable,
  input  logic                          flush,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic [PADDR_W-1:0]            rsp_paddr,
  output logic                          rsp_wr_fault,
  output logic                          evict_valid,
  output logic [VADDR_W-OFFSET_W-1:0]   evict_vpn,
  output logic                          evict_dirty,
  output logic                          evict_ref
);

  localparam int unsigned VPN_W = VADDR_W - OFFSET_W;
  localparam int unsigned PPN_W = PADDR_W - OFFSET_W;
  localparam int unsigned IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST_SLOT = IW'(ENTRIES - 1);

  // Address arithmetic, kept in functions.
  function automatic logic [VPN_W-1:0] vpn_of(input logic [VADDR_W-1:0] va);
    return va[VADDR_W-1:OFFSET_W];
  endfunction

  function automatic logic [OFFSET_W-1:0] offset_of(input logic [VADDR_W-1:0] va);
    return va[OFFSET_W-1:0];
  endfunction

  function automatic logic [PADDR_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                                 input logic [OFFSET_W-1:0] off);
    return {ppn, off};
  endfunction

  function automatic logic [IW-1:0] next_slot(input logic [IW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  // Entry storage.
  logic [ENTRIES-1:0] valid_q, refd_q, dirty_q, wable_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IW-1:0]      sweep_ptr_q;

  logic [ENTRIES*VPN_W-1:0] tag_flat;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign tag_flat[g*VPN_W +: VPN_W] = tag_q[g];
  end

  // Lookup path.
  logic [VPN_W-1:0]    lk_vpn;
  logic [ENTRIES-1:0]  lk_match;
  logic                lk_found;
  logic [IW-1:0]       lk_idx;
  logic                lk_hit;
  logic                lk_set_dirty;
  logic                lk_fault;

  assign lk_vpn = vpn_of(req_vaddr);

  xlat_cam #(.N(ENTRIES), .TAG_W(VPN_W)) i_lookup_cam (
    .tags_flat(tag_flat), .valid(valid_q), .key(lk_vpn), .match(lk_match)
  );

  xlat_first_set #(.N(ENTRIES), .IW(IW)) i_lookup_enc (
    .vec(lk_match), .found(lk_found), .idx(lk_idx)
  );

  assign lk_hit       = req_valid && lk_found;
  assign lk_set_dirty = lk_hit && req_write && wable_q[lk_idx];
  assign lk_fault     = lk_hit && req_write && !wable_q[lk_idx];

  // Fill path.
  logic [ENTRIES-1:0] fl_match;
  logic [IW-1:0]      vic_idx;
  vic_kind_e          vic_kind;
  logic               fill_fire;
  logic               sweep_fire;
  logic               vic_worth;

  xlat_cam #(.N(ENTRIES), .TAG_W(VPN_W)) i_fill_cam (
    .tags_flat(tag_flat), .valid(valid_q), .key(fill_vpn), .match(fl_match)
  );

  xlat_victim #(.N(ENTRIES), .IW(IW)) i_victim (
    .same_vec (fl_match),
    .valid    (valid_q),
    .refd     (refd_q),
    .sweep_ptr(sweep_ptr_q),
    .vic_idx  (vic_idx),
    .vic_kind (vic_kind)
  );

  assign fill_fire  = fill_valid && !flush;
  assign sweep_fire = fill_fire && (vic_kind == VIC_SWEEP);
  assign vic_worth  = valid_q[vic_idx] && (dirty_q[vic_idx] || refd_q[vic_idx]);

  // Next state of the status bits: sweep clear, then hit update, then fill, flush last.
  logic [ENTRIES-1:0] valid_n, refd_n, dirty_n;

  always_comb begin
    valid_n = valid_q;
    refd_n  = sweep_fire ? '0 : refd_q;
    dirty_n = dirty_q;
    if (lk_hit) begin
      refd_n[lk_idx] = 1'b1;
      if (lk_set_dirty) dirty_n[lk_idx] = 1'b1;
    end
    if (fill_fire) begin
      valid_n[vic_idx] = 1'b1;
      refd_n[vic_idx]  = 1'b0;
      dirty_n[vic_idx] = 1'b0;
    end
    if (flush) begin
      valid_n = '0;
      refd_n  = '0;
      dirty_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= '0;
      refd_q      <= '0;
      dirty_q     <= '0;
      sweep_ptr_q <= '0;
    end else begin
      valid_q <= valid_n;
      refd_q  <= refd_n;
      dirty_q <= dirty_n;
      if (sweep_fire) sweep_ptr_q <= next_slot(sweep_ptr_q);
    end
  end

  // Mapping payload needs no reset: valid bits guard it.
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      tag_q[vic_idx]   <= fill_vpn;
      ppn_q[vic_idx]   <= fill_ppn;
      wable_q[vic_idx] <= fill_writable;
    end
  end

  // Response and eviction registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_paddr    <= '0;
      rsp_wr_fault <= 1'b0;
      evict_valid  <= 1'b0;
      evict_vpn    <= '0;
      evict_dirty  <= 1'b0;
      evict_ref    <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= lk_hit;
      rsp_paddr    <= lk_hit ? join_pa(ppn_q[lk_idx], offset_of(req_vaddr)) : '0;
      rsp_wr_fault <= lk_fault;
      evict_valid  <= fill_fire && vic_worth;
      evict_vpn    <= tag_q[vic_idx];
      evict_dirty  <= dirty_q[vic_idx];
      evict_ref    <= refd_q[vic_idx];
    end
  end

  // Assertions.
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_miss_zero_pa_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));
  assert_fault_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_fault |-> (rsp_valid && rsp_hit));
  assert_evict_has_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (evict_dirty || evict_ref));
  assert_evict_after_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_valid || flush) |=> !evict_valid);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
  assert_fill_installs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (valid_q != '0));
  assert_single_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  assert_single_fill_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl_match));

endmodule

// File: tb/test_xlat_tlb.sv
`timescale 1ns/1ps
module test_xlat_tlb;

  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  logic        fill_writable = 1'b0;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_wr_fault;
  logic [29:0] rsp_paddr;
  logic        evict_valid, evict_dirty, evict_ref;
  logic [19:0] evict_vpn;

  always #2 clk = ~clk;

  xlat_tlb i_xlat_tlb (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_writable(fill_writable), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_wr_fault(rsp_wr_fault), .evict_valid(evict_valid),
    .evict_vpn(evict_vpn), .evict_dirty(evict_dirty), .evict_ref(evict_ref)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Behavioural reference: one record per slot plus the rotation counter.
  bit          m_v [NE];
  logic [19:0] m_tag [NE];
  logic [17:0] m_ppn [NE];
  bit          m_w [NE];
  bit          m_d [NE];
  bit          m_r [NE];
  int          m_rot = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit rv, input logic [31:0] va, input bit wr,
                      input bit fv, input logic [19:0] fvpn, input logic [17:0] fppn,
                      input bit fw, input bit fl, input string req);
    bit e_hit, e_flt, e_ev, e_ed, e_er, sweep;
    logic [29:0] e_pa;
    logic [19:0] e_evpn;
    int hi, vi;
    @(negedge clk);
    req_valid = rv; req_vaddr = va; req_write = wr;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_writable = fw;
    flush = fl;
    e_hit = 0; hi = -1;
    if (rv) for (int i = 0; i < NE; i++)
      if (m_v[i] && m_tag[i] == va[31:12]) begin e_hit = 1; hi = i; end
    e_pa  = e_hit ? {m_ppn[hi], va[11:0]} : 30'd0;
    e_flt = e_hit && wr && !m_w[hi];
    e_ev = 0; e_ed = 0; e_er = 0; e_evpn = '0;
    if (fl) begin
      for (int i = 0; i < NE; i++) begin m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; end
    end else begin
      vi = -1; sweep = 0;
      if (fv) begin
        for (int i = 0; i < NE; i++) if (vi < 0 && m_v[i] && m_tag[i] == fvpn) vi = i;
        for (int i = 0; i < NE; i++) if (vi < 0 && !m_v[i]) vi = i;
        for (int i = 0; i < NE; i++) if (vi < 0 && !m_r[i]) vi = i;
        if (vi < 0) begin vi = m_rot; sweep = 1; end
        e_ev = m_v[vi] && (m_d[vi] || m_r[vi]);
        e_evpn = m_tag[vi]; e_ed = m_d[vi]; e_er = m_r[vi];
        if (sweep) begin
          for (int i = 0; i < NE; i++) m_r[i] = 0;
          m_rot = (m_rot + 1) % NE;
        end
      end
      if (e_hit) begin
        m_r[hi] = 1;
        if (wr && m_w[hi]) m_d[hi] = 1;
      end
      if (fv) begin
        m_v[vi] = 1; m_tag[vi] = fvpn; m_ppn[vi] = fppn; m_w[vi] = fw;
        m_d[vi] = 0; m_r[vi] = 0;
      end
    end
    @(posedge clk);
    #1;
    chk("R2", "rsp_valid", 32'(rsp_valid), 32'(rv));
    if (rv) begin
      chk(req, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
      chk(req, "rsp_paddr", 32'(rsp_paddr), 32'(e_pa));
      chk(req, "rsp_wr_fault", 32'(rsp_wr_fault), 32'(e_flt));
    end
    chk(req, "evict_valid", 32'(evict_valid), 32'(e_ev));
    if (e_ev) begin
      chk(req, "evict_vpn", 32'(evict_vpn), 32'(e_evpn));
      chk(req, "evict_dirty", 32'(evict_dirty), 32'(e_ed));
      chk(req, "evict_ref", 32'(evict_ref), 32'(e_er));
    end
  endtask

  function automatic logic [31:0] va_of(input logic [19:0] vpn, input logic [11:0] off);
    return {vpn, off};
  endfunction

  task automatic rd(input logic [31:0] va, input string req);
    step(1, va, 0, 0, '0, '0, 0, 0, req);
  endtask
  task automatic wrq(input logic [31:0] va, input string req);
    step(1, va, 1, 0, '0, '0, 0, 0, req);
  endtask
  task automatic fill(input logic [19:0] vpn, input logic [17:0] ppn, input bit w,
                      input string req);
    step(0, '0, 0, 1, vpn, ppn, w, 0, req);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_w[i] = 0; m_tag[i] = '0; m_ppn[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: quiet outputs after reset, and any lookup misses.
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "evict_valid after reset", 32'(evict_valid), 32'd0);
    rd(va_of(20'h00000, 12'h000), "R1");
    rd(va_of(20'hABCDE, 12'h123), "R1");

    // R3 / R4: basic translation, read and write hits.
    fill(20'h12345, 18'h2A5A5, 1, "R10");
    rd(va_of(20'h12345, 12'hFED), "R3");
    wrq(va_of(20'h12345, 12'h001), "R4");
    rd(va_of(20'h12346, 12'h001), "R3");
    fill(20'h00777, 18'h00011, 1, "R6");
    rd(va_of(20'h00777, 12'h800), "R3");

    // R5: write to read-only page.
    fill(20'h0BEEF, 18'h3FFFF, 0, "R6");
    wrq(va_of(20'h0BEEF, 12'h0F0), "R5");
    rd(va_of(20'h0BEEF, 12'h0F0), "R5");

    // R6: same-page refill replaces in place and reports its status.
    fill(20'h12345, 18'h11111, 1, "R6");
    rd(va_of(20'h12345, 12'h004), "R6");

    // Fill the remaining slots, then exercise cold selection.
    for (int k = 0; k < 13; k++) fill(20'h40000 + 20'(k), 18'(k + 100), 1, "R6");
    rd(va_of(20'h40000, 12'h0), "R4");
    fill(20'h50000, 18'h00050, 1, "R6");
    fill(20'h50001, 18'h00051, 1, "R6");

    // R7: reference everything, then fill repeatedly to drive the rotation.
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < NE; i++)
        if (m_v[i]) wrq(va_of(m_tag[i], 12'h010), "R4");
      fill(20'h60000 + 20'(s), 18'h00060 + 18'(s), 1, "R7");
      rd(va_of(20'h60000 + 20'(s), 12'h0), "R8");
    end

    // R10: fill replacing the slot hit in the same cycle.
    for (int i = 0; i < NE; i++) if (m_v[i]) rd(va_of(m_tag[i], 12'h0), "R4");
    step(1, va_of(m_tag[m_rot], 12'h5), 1, 1, 20'h70000, 18'h00070, 1, 0, "R10");
    rd(va_of(20'h70000, 12'h5), "R10");

    // R9: flush with a same-cycle fill and request.
    step(1, va_of(20'h70000, 12'h6), 0, 1, 20'h71000, 18'h00071, 1, 1, "R9");
    rd(va_of(20'h70000, 12'h6), "R9");
    rd(va_of(20'h71000, 12'h6), "R9");
    fill(20'h72000, 18'h00072, 1, "R9");
    rd(va_of(20'h72000, 12'h7), "R9");

    // Random traffic over a small page pool (R11 via single-hit results).
    for (int t = 0; t < 5000; t++) begin
      bit rv, wr, fv, fl;
      logic [19:0] pv, fp;
      rv = ($urandom_range(0, 9) < 7);
      wr = $urandom_range(0, 1);
      fv = ($urandom_range(0, 3) == 0);
      fl = ($urandom_range(0, 199) == 0);
      pv = 20'h30000 + 20'($urandom_range(0, 39));
      fp = 20'h30000 + 20'($urandom_range(0, 39));
      step(rv, {pv, 12'($urandom)}, wr, fv, fp, 18'($urandom), 1'($urandom), fl, "R11");
    end

    finish_run();
  end

endmodule